// File: doc/BRIEF.md
# Round-Robin Address Translation Buffer with Hardware Page Walk

This block translates virtual byte addresses into physical addresses for a small paged machine with 16-byte pages. It keeps four translations, each comparable against the incoming virtual page number in parallel. Each translation carries its own read, write and execute permissions, and every access is checked against them. The low four address bits pass through unchanged.

A requester presents an address, an access kind and a strobe. It holds them until `req_done` rises. A hit, a permission fault or a misaligned access finishes in the cycle it is presented. On a miss the block reads one page-table word from physical memory and installs the translation in the slot named by a rotating fill pointer. It then repeats the lookup. A page-table word marked invalid ends the access with a page fault.

The page table sits at physical address zero, with one 32-bit word per virtual page. Page n's word is at byte address 4·n. The word layout is as follows:
- bit 31: valid
- bit 30: read
- bit 29: write
- bit 28: execute
- low `PPN_W` bits: the frame number

Top module: `rr_xlate_tlb`

## Requirements
- R1: After reset no translation is held and the fill pointer is at slot 0, so the first access to any aligned page starts a page-table read.
- R2: An access whose address bits [1:0] are not 00 completes in its first cycle with `req_exc`=1 and `req_cause`=2. No page-table read is made, and this holds even when the page is unmapped or not held.
- R3: A hit with the needed permission completes in its first cycle with `req_exc`=0 and `req_paddr` = {frame number, vaddr[3:0]}.
- R4: On a miss, `mem_rd` pulses for one cycle at byte address 4·VPN, and `req_done` stays low in that cycle. A valid response installs the translation, and the access completes one cycle after the response: three cycles in all with a one-cycle memory.
- R5: A page-table word with bit 31 clear ends the access in the response cycle with `req_cause`=1. No translation is installed and the fill pointer does not move, so a repeat access walks again.
- R6: Access kinds are encoded as 0 = fetch (needs execute, bit 28), 1 = load (needs read, bit 30) and 2 = store (needs write, bit 29). A held translation lacking the needed bit completes in one cycle with `req_cause`=1 and leaves all held translations unchanged.
- R7: Successive fills go to slots 0, 1, 2, 3, 0, … The pointer advances by one, modulo four, after each fill only.
- R8: A hit makes no memory read and changes no state. A held translation stays in use even if its page-table word is later changed in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe, held until `req_done` |
| req_vaddr | input | VA_W | Virtual byte address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_done | output | 1 | Access finished this cycle |
| req_paddr | output | PPN_W+4 | Physical address (valid when done without exception) |
| req_exc | output | 1 | Access ended in an exception |
| req_cause | output | 2 | 1 page fault, 2 misaligned |
| mem_rd | output | 1 | Page-table word read strobe |
| mem_addr | output | PPN_W+4 | Byte address of the page-table word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page-table word |

## Verification
Two checks can fall in the same cycle: the alignment test and the lookup that would otherwise start a walk or report a permission fault. The bench provokes this by presenting misaligned addresses on a page whose table word is invalid and on a page held without write permission. It judges the result by the cause being 2, the absence of any `mem_rd` pulse, and completion in one cycle. Installing a translation and moving the fill pointer past its last slot also coincide. This is judged by later hit/miss latencies that reveal which translation was evicted.

// File: rtl/xl_pkg.sv
package xl_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] CAUSE_PAGE_FAULT = 2'd1;
    localparam logic [1:0] CAUSE_UNALIGNED  = 2'd2;

    // page-table word layout
    localparam int PTE_V_BIT = 31;
    localparam int PTE_R_BIT = 30;
    localparam int PTE_W_BIT = 29;
    localparam int PTE_X_BIT = 28;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WAIT = 1'b1
    } walk_e;

endpackage

// File: rtl/xl_tag_match.sv
module xl_tag_match #(
    parameter int N     = 4,
    parameter int VPN_W = 4,
    parameter int PPN_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              vld,
    input  logic [N-1:0][VPN_W-1:0]   vpn_tab,
    input  logic [N-1:0][PPN_W-1:0]   ppn_tab,
    input  logic [N-1:0][2:0]         perm_tab,
    input  logic [VPN_W-1:0]          look_vpn,
    output logic [N-1:0]              hit_vec,
    output logic                      hit,
    output logic [PPN_W-1:0]          hit_ppn,
    output logic [2:0]                hit_perm
);

    // every slot compared at once
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (vpn_tab[g] == look_vpn);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_ppn  = hit_ppn | ppn_tab[i];
                hit_perm = hit_perm | perm_tab[i];
            end
        end
    end

    // R8: fills only happen on a miss, so a page is never held twice
    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/xl_access_check.sv
module xl_access_check
    import xl_pkg::*;
(
    input  acc_kind_e  kind,
    input  logic [1:0] low_bits,
    input  perm_t      perm,
    output logic       misaligned,
    output logic       perm_fault
);

    assign misaligned = (low_bits != 2'b00);

    always_comb begin
        unique case (kind)
            ACC_FETCH: perm_fault = !perm.x;
            ACC_STORE: perm_fault = !perm.w;
            default:   perm_fault = !perm.r;
        endcase
    end

endmodule

// File: rtl/rr_xlate_tlb.sv
module rr_xlate_tlb
    import xl_pkg::*;
#(
    parameter int VA_W    = 8,
    parameter int PPN_W   = 4,
    parameter int ENTRIES = 4,
    parameter int WORD_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_kind,
    output logic                  req_done,
    output logic [PPN_W+3:0]      req_paddr,
    output logic                  req_exc,
    output logic [1:0]            req_cause,
    output logic                  mem_rd,
    output logic [PPN_W+3:0]      mem_addr,
    input  logic                  mem_rvalid,
    input  logic [WORD_W-1:0]     mem_rdata
);

    localparam int OFF_W = 4;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int PTA_W = VPN_W + 2;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        perm_t [ENTRIES-1:0]            perm;
        logic [IDX_W-1:0]               nxt;
        walk_e                          fsm;
    } state_t;

    state_t st_d, st_q;

    logic [VPN_W-1:0]   look_vpn;
    logic [ENTRIES-1:0] hit_vec;
    logic               hit;
    logic [PPN_W-1:0]   hit_ppn;
    logic [2:0]         hit_perm_raw;
    perm_t              hit_perm;
    logic               misaligned;
    logic               perm_fault;
    logic               pte_valid;
    perm_t              pte_perm;
    logic [PPN_W-1:0]   pte_ppn;
    logic               unused_pte_bits;

    assign look_vpn  = req_vaddr[VA_W-1:OFF_W];
    assign hit_perm  = perm_t'(hit_perm_raw);
    assign pte_valid = mem_rdata[PTE_V_BIT];
    assign pte_perm  = '{r: mem_rdata[PTE_R_BIT], w: mem_rdata[PTE_W_BIT], x: mem_rdata[PTE_X_BIT]};
    assign pte_ppn   = mem_rdata[PPN_W-1:0];
    assign unused_pte_bits = ^mem_rdata[PTE_X_BIT-1:PPN_W];

    xl_tag_match #(
        .N     (ENTRIES),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (st_q.vld),
        .vpn_tab  (st_q.vpn),
        .ppn_tab  (st_q.ppn),
        .perm_tab (st_q.perm),
        .look_vpn (look_vpn),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .hit_perm (hit_perm_raw)
    );

    xl_access_check u_check (
        .kind       (acc_kind_e'(req_kind)),
        .low_bits   (req_vaddr[1:0]),
        .perm       (hit_perm),
        .misaligned (misaligned),
        .perm_fault (perm_fault)
    );

    assign mem_addr = PA_W'({look_vpn, 2'b00});

    always_comb begin
        st_d      = st_q;
        req_done  = 1'b0;
        req_exc   = 1'b0;
        req_cause = 2'd0;
        req_paddr = '0;
        mem_rd    = 1'b0;
        unique case (st_q.fsm)
            WS_IDLE: begin
                if (req_valid) begin
                    if (misaligned) begin
                        req_done  = 1'b1;
                        req_exc   = 1'b1;
                        req_cause = CAUSE_UNALIGNED;
                    end else if (hit) begin
                        req_done = 1'b1;
                        if (perm_fault) begin
                            req_exc   = 1'b1;
                            req_cause = CAUSE_PAGE_FAULT;
                        end else begin
                            req_paddr = {hit_ppn, req_vaddr[OFF_W-1:0]};
                        end
                    end else begin
                        mem_rd    = 1'b1;
                        st_d.fsm  = WS_WAIT;
                    end
                end
            end
            WS_WAIT: begin
                if (mem_rvalid) begin
                    st_d.fsm = WS_IDLE;
                    if (pte_valid) begin
                        st_d.vld[st_q.nxt]  = 1'b1;
                        st_d.vpn[st_q.nxt]  = look_vpn;
                        st_d.ppn[st_q.nxt]  = pte_ppn;
                        st_d.perm[st_q.nxt] = pte_perm;
                        st_d.nxt = (st_q.nxt == LAST_IDX) ? '0 : st_q.nxt + IDX_W'(1);
                    end else begin
                        req_done  = 1'b1;
                        req_exc   = 1'b1;
                        req_cause = CAUSE_PAGE_FAULT;
                    end
                end
            end
            default: st_d.fsm = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a walk is never started for a misaligned address
    p_rd_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (req_vaddr[1:0] == 2'b00));

    // R4: the access is not finished in the cycle the walk starts
    p_rd_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !req_done);

    // R4: one read per walk
    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R7: pointer steps by one, wrapping, after a fill
    p_fill_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == WS_WAIT && mem_rvalid && pte_valid) |=>
        (st_q.nxt == (($past(st_q.nxt) == LAST_IDX) ? '0 : $past(st_q.nxt) + IDX_W'(1))));

    // R5: an invalid table word installs nothing
    p_fault_nofill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == WS_WAIT && mem_rvalid && !pte_valid) |=>
        ($stable(st_q.vld) && $stable(st_q.nxt)));

    // R6 and R8: a completed access in the idle state leaves the held translations alone
    p_idle_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == WS_IDLE && req_done) |=> $stable(st_q));

endmodule

// File: tb/rr_xlate_tlb_tb.sv
`timescale 1ns/1ps
module rr_xlate_tlb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_done;
    logic [7:0]  req_paddr;
    logic        req_exc;
    logic [1:0]  req_cause;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:15];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rr_xlate_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_done(req_done), .req_paddr(req_paddr),
        .req_exc(req_exc), .req_cause(req_cause), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // one-cycle page-table memory
    always_ff @(posedge clk) begin
        mem_rvalid <= mem_rd;
        mem_rdata  <= mem[mem_addr[5:2]];
    end

    function automatic logic [31:0] pte(input bit v, input bit r, input bit w, input bit x, input int ppn);
        return {v, r, w, x, 24'd0, 4'(ppn)};
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic access(input logic [7:0] va, input logic [1:0] kind,
                          output int cyc, output int rds, output logic [7:0] pa,
                          output logic ex, output logic [1:0] cs);
        bit fin;
        @(negedge clk);
        req_vaddr = va; req_kind = kind; req_valid = 1'b1;
        cyc = 0; rds = 0; fin = 0;
        while (!fin) begin
            #1;
            cyc++;
            if (mem_rd) rds++;
            if (req_done || cyc > 20) fin = 1;
            else @(negedge clk);
        end
        pa = req_paddr; ex = req_exc; cs = req_cause;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // kind: 0 fetch, 1 load, 2 store
    task automatic expect_acc(input string req, input logic [7:0] va, input logic [1:0] kind,
                              input int e_cyc, input int e_rds, input bit e_exc,
                              input int e_cause, input int e_pa);
        int cyc, rds; logic [7:0] pa; logic ex; logic [1:0] cs;
        access(va, kind, cyc, rds, pa, ex, cs);
        check(req, $sformatf("cycles va=%0h", va), cyc, e_cyc);
        check(req, $sformatf("reads va=%0h", va), rds, e_rds);
        check(req, $sformatf("exc va=%0h", va), int'(ex), int'(e_exc));
        if (e_exc) check(req, $sformatf("cause va=%0h", va), int'(cs), e_cause);
        else       check(req, $sformatf("paddr va=%0h", va), int'(pa), e_pa);
    endtask

    // page n maps to frame 15-n
    function automatic int pa_of(input int vpn, input int off);
        return ((15 - vpn) << 4) | off;
    endfunction

    task automatic t_reset_r1;
        #1;
        check("R1", "done idle", int'(req_done), 0);
        check("R1", "mem_rd idle", int'(mem_rd), 0);
        // R1 R4: first access walks, 3 cycles
        expect_acc("R1", 8'h24, 2'd1, 3, 1, 0, 0, pa_of(2, 4));
    endtask

    task automatic t_hit_r3;
        expect_acc("R3", 8'h28, 2'd1, 1, 0, 0, 0, pa_of(2, 8));
        expect_acc("R3", 8'h2C, 2'd2, 1, 0, 0, 0, pa_of(2, 12));
        expect_acc("R3", 8'h20, 2'd0, 1, 0, 0, 0, pa_of(2, 0));
    endtask

    task automatic t_unaligned_r2;
        expect_acc("R2", 8'h91, 2'd2, 1, 0, 1, 2, 0);
        expect_acc("R2", 8'h72, 2'd1, 1, 0, 1, 2, 0);  // invalid page: cause stays 2
        expect_acc("R2", 8'h23, 2'd1, 1, 0, 1, 2, 0);  // held page
    endtask

    task automatic t_invalid_r5;
        expect_acc("R5", 8'h70, 2'd1, 2, 1, 1, 1, 0);
        expect_acc("R5", 8'h74, 2'd1, 2, 1, 1, 1, 0);  // walks again
    endtask

    task automatic t_perm_r6;
        expect_acc("R6", 8'h60, 2'd1, 3, 1, 0, 0, pa_of(6, 0)); // fill slot 1
        expect_acc("R6", 8'h64, 2'd2, 1, 0, 1, 1, 0);          // store, no W
        expect_acc("R6", 8'h68, 2'd0, 1, 0, 1, 1, 0);          // fetch, no X
        expect_acc("R6", 8'h61, 2'd2, 1, 0, 1, 2, 0);          // misaligned wins
        expect_acc("R6", 8'h6C, 2'd1, 1, 0, 0, 0, pa_of(6, 12)); // still held
    endtask

    task automatic t_rr_r7;
        // slots: 0=p2 1=p6; R5 walks did not move the pointer
        expect_acc("R7", 8'hA0, 2'd1, 3, 1, 0, 0, pa_of(10, 0)); // slot 2
        expect_acc("R7", 8'hB0, 2'd1, 3, 1, 0, 0, pa_of(11, 0)); // slot 3
        expect_acc("R7", 8'hC0, 2'd1, 3, 1, 0, 0, pa_of(12, 0)); // slot 0, evicts p2
        expect_acc("R7", 8'h60, 2'd1, 1, 0, 0, 0, pa_of(6, 0));  // p6 held
        expect_acc("R7", 8'h20, 2'd1, 3, 1, 0, 0, pa_of(2, 0));  // slot 1, evicts p6
        expect_acc("R7", 8'hA4, 2'd1, 1, 0, 0, 0, pa_of(10, 4)); // p10 held
        expect_acc("R7", 8'h60, 2'd1, 3, 1, 0, 0, pa_of(6, 0));  // slot 2, evicts p10
        expect_acc("R7", 8'hB4, 2'd1, 1, 0, 0, 0, pa_of(11, 4)); // p11 held
    endtask

    task automatic t_stale_r8;
        // p11 in slot 3, p12 in slot 0; change p12's table word
        mem[12] = pte(1, 1, 1, 1, 5);
        expect_acc("R8", 8'hC8, 2'd1, 1, 0, 0, 0, pa_of(12, 8)); // old frame used
        expect_acc("R8", 8'hA0, 2'd1, 3, 1, 0, 0, pa_of(10, 0)); // slot 3, evicts p11
        expect_acc("R8", 8'hB0, 2'd1, 3, 1, 0, 0, pa_of(11, 0)); // slot 0, evicts p12
        expect_acc("R8", 8'hC8, 2'd1, 3, 1, 0, 0, (5 << 4) | 8); // new frame
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = pte(1, 1, 1, 1, 15 - i);
        mem[7] = pte(0, 1, 1, 1, 8);
        mem[6] = pte(1, 1, 0, 0, 9);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_hit_r3();
        t_unaligned_r2();
        t_invalid_r5();
        t_perm_r6();
        t_rr_r7();
        t_stale_r8();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule